// File: doc/BRIEF.md
# Secure-aware interrupt state bitmap bank

This block keeps three state bits for every shared peripheral interrupt: enable, pending and active. Software reaches each state through two windows of 32-bit words. A "set" window turns bits on where the written data has ones. A "clear" window turns bits off where the written data has ones. Zeros in the written data leave bits as they are. Word index `w` of a window covers interrupt IDs `32*w` up to `32*w+31`. Word 0 holds the internal IDs, which are reserved. Words at or above the implemented count are also reserved.

Every access carries a secure flag, and each data bit is masked before it is read or written. A secure access sees every bit. So does any access while the global security-disable input is high. A non-secure access with security enabled sees a bit only when that interrupt is in the non-secure group, or when the interrupt's 2-bit non-secure permission field grants the operation. Those fields live in a small store that only secure software can program.

Pending has two sources. The first is a latch, which software writes and a rising edge on an edge-triggered input line sets. The second is the live level of each level-triggered line, which is merged into the pending value both on readback and at the outputs. Priority arbitration, CPU delivery and routing live in neighbouring blocks that consume the per-interrupt outputs.

Top module: `irq_state_bank`

## Requirements
- R1: After reset every enable, pending latch, active bit and permission field is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: Word 0 (IDs below 32) and every word index at or above `NUM_IRQ/32` read as 0 in all bitmap windows, and writes to them change no state and no output.
- R3: In a set window (region 0 enable, 2 pending, 4 active), each permitted 1 in the write data sets the bit, and 0 bits change nothing. The set and clear windows of one state read back the same value.
- R4: In a clear window (region 1 enable, 3 pending, 5 active), each permitted 1 in the write data clears the bit, and 0 bits change nothing.
- R5: A secure access, or any access while `sec_disable` is 1, is permitted on all 32 bits of a word.
- R6: A non-secure access while `sec_disable` is 0 is permitted on bit i only if `irq_group[i]` is 1 (non-secure group), or if the permission field of interrupt i allows the operation. The enable windows consult no permission field.
- R7: Permission field values mean the following. A value of 1 or more allows set-pending read and write. A value of 2 or more also allows clear-pending read and write and active reads. Active writes consult only the group bit.
- R8: Effective pending for a line is its latch ORed with (`irq_level` AND NOT `irq_edge`). Both the pending windows and `pend_o` present this value, combinationally from the level.
- R9: A 0-to-1 change of `irq_level` on a line with `irq_edge`=1 sets its latch at the next edge. A steady level does not set it, and neither does a rise on a level-triggered line. A rise wins over a clear-pending write in the same cycle.
- R10: Permission word n (word address 192+n) holds the fields of IDs 16n..16n+15, with interrupt 16n+k at bits [2k+1:2k]. It is read and written only by secure accesses while `sec_disable` is 0. Otherwise it reads 0 and ignores writes, as do words 0 and 1 and words at or above `NUM_IRQ/16`.
- R11: A write takes effect at the clock edge that samples `bus_wr`. A read sampled at an edge returns its data on `bus_rdata`, with `bus_rvalid` high, for the following cycle.
- R12: The word address uses bits [7:5] as the region (0..5 bitmap windows, 6 and 7 permission store). For bitmap regions bits [4:0] are the word index. For the permission store bits [5:0] are the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_disable | input | 1 | 1 = single security state, all accesses fully permitted |
| irq_level | input | NUM_IRQ | Live input level per interrupt line |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_group | input | NUM_IRQ | 1 = interrupt belongs to the non-secure group |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_secure | input | 1 | 1 = secure access |
| bus_word_addr | input | 8 | Word address (region and word index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for the cycle in which `bus_rdata` holds a read result |
| enable_o | output | NUM_IRQ | Per-interrupt enable |
| pend_o | output | NUM_IRQ | Per-interrupt effective pending |
| active_o | output | NUM_IRQ | Per-interrupt active |

## Verification
A write is sampled at one rising edge, and the state it touches, together with `enable_o`, `active_o` and the latch part of `pend_o`, changes at that same edge. The bench therefore drives stimulus on falling edges and checks outputs on the next falling edge. The level part of `pend_o` follows `irq_level` without a register. An edge-triggered rise shows up in the latch one edge after the level changes. Read data is due one edge after the request. The driver queues each expected word as it issues the read, and a monitor pops the queue at every falling edge that has `bus_rvalid` high. A read that never arrives is therefore caught as a non-empty queue at the end.

// File: rtl/irq_state_bank_pkg.sv
package irq_state_bank_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned WADDR_W = 8;

  typedef enum logic [2:0] {
    RG_SET_EN   = 3'd0,
    RG_CLR_EN   = 3'd1,
    RG_SET_PEND = 3'd2,
    RG_CLR_PEND = 3'd3,
    RG_SET_ACT  = 3'd4,
    RG_CLR_ACT  = 3'd5,
    RG_PERM_LO  = 3'd6,
    RG_PERM_HI  = 3'd7
  } region_e;

  typedef enum logic [1:0] {
    NEED_NONE = 2'd0,
    NEED_GE1  = 2'd1,
    NEED_GE2  = 2'd2
  } perm_need_e;

  // Grant vector from a pair of permission words covering 32 interrupts.
  function automatic logic [WORD_W-1:0] perm_grant(input logic [2*WORD_W-1:0] pair,
                                                   input perm_need_e need);
    logic [WORD_W-1:0] g;
    g = '0;
    for (int i = 0; i < WORD_W; i++) begin
      unique case (need)
        NEED_GE1: g[i] = |pair[2*i +: 2];
        NEED_GE2: g[i] = pair[2*i + 1];
        default:  g[i] = 1'b0;
      endcase
    end
    return g;
  endfunction

  function automatic logic [WORD_W-1:0] access_mask(input logic secure,
                                                    input logic sec_dis,
                                                    input logic [WORD_W-1:0] group,
                                                    input logic [2*WORD_W-1:0] pair,
                                                    input perm_need_e need);
    if (secure || sec_dis) return '1;
    return group | perm_grant(pair, need);
  endfunction

  function automatic perm_need_e need_for_read(input region_e rg);
    unique case (rg)
      RG_SET_PEND:            return NEED_GE1;
      RG_CLR_PEND,
      RG_SET_ACT, RG_CLR_ACT: return NEED_GE2;
      default:                return NEED_NONE;
    endcase
  endfunction

  function automatic perm_need_e need_for_write(input region_e rg);
    unique case (rg)
      RG_SET_PEND: return NEED_GE1;
      RG_CLR_PEND: return NEED_GE2;
      default:     return NEED_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_access_mask.sv
module irq_access_mask
  import irq_state_bank_pkg::*;
(
  input  logic                secure,
  input  logic                sec_dis,
  input  logic [WORD_W-1:0]   group,
  input  logic [2*WORD_W-1:0] perm_pair,
  input  perm_need_e          need,
  output logic [WORD_W-1:0]   mask
);
  assign mask = access_mask(secure, sec_dis, group, perm_pair, need);
endmodule

// File: rtl/irq_perm_store.sv
module irq_perm_store
  import irq_state_bank_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 96,
  localparam int unsigned NWORDS = NUM_IRQ / 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_sel,
  input  logic                       secure,
  input  logic                       sec_dis,
  input  logic [5:0]                 idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rd_word,
  output logic [NWORDS*WORD_W-1:0]   flat_o
);
  logic [WORD_W-1:0] mem_q [NWORDS];
  logic              allowed;
  logic              idx_ok;
  logic              do_write;

  assign allowed  = secure && !sec_dis;
  assign idx_ok   = (idx >= 6'd2) && (32'(idx) < NWORDS);
  assign do_write = wr_en && allowed && idx_ok;

  for (genvar n = 0; n < NWORDS; n++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem_q[n] <= '0;
      else if (do_write && (idx == 6'(n)))         mem_q[n] <= wdata;
    end
    assign flat_o[n*WORD_W +: WORD_W] = mem_q[n];
  end

  always_comb begin
    rd_word = '0;
    for (int n = 0; n < NWORDS; n++)
      if (rd_sel && allowed && idx_ok && (idx == 6'(n))) rd_word = mem_q[n];
  end

  // R10
  perm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !allowed) |=> $stable(flat_o));

endmodule

// File: rtl/irq_state_word.sv
module irq_state_word
  import irq_state_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] level,
  input  logic [WORD_W-1:0] edge_cfg,
  input  logic [WORD_W-1:0] en_set,
  input  logic [WORD_W-1:0] en_clr,
  input  logic [WORD_W-1:0] pd_set,
  input  logic [WORD_W-1:0] pd_clr,
  input  logic [WORD_W-1:0] ac_set,
  input  logic [WORD_W-1:0] ac_clr,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] pd_q,
  output logic [WORD_W-1:0] ac_q,
  output logic [WORD_W-1:0] pd_eff
);
  logic [WORD_W-1:0] lvl_q;
  logic [WORD_W-1:0] rise;

  assign rise   = level & ~lvl_q & edge_cfg;
  assign pd_eff = pd_q | (level & ~edge_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= '0;
      pd_q  <= '0;
      ac_q  <= '0;
    end else begin
      lvl_q <= level;
      en_q  <= (en_q & ~en_clr) | en_set;
      pd_q  <= (pd_q & ~pd_clr) | pd_set | rise;
      ac_q  <= (ac_q & ~ac_clr) | ac_set;
    end
  end

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set)));
  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((en_q & $past(en_clr)) == '0));
  // R4
  pd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pd_clr & ~rise & ~pd_set)) |=> ((pd_q & $past(pd_clr & ~rise & ~pd_set)) == '0));
  // R9
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pd_q & $past(rise)) == $past(rise)));
  // R3
  ac_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ac_set) |=> ((ac_q & $past(ac_set)) == $past(ac_set)));

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_state_bank_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_disable,
  input  logic [NUM_IRQ-1:0]   irq_level,
  input  logic [NUM_IRQ-1:0]   irq_edge,
  input  logic [NUM_IRQ-1:0]   irq_group,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_secure,
  input  logic [7:0]           bus_word_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_IRQ-1:0]   enable_o,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic [NUM_IRQ-1:0]   active_o
);
  localparam int unsigned NWORDS  = NUM_IRQ / WORD_W;
  localparam int unsigned PWORDS  = NUM_IRQ / 16;

  region_e           region;
  logic [4:0]        widx;
  logic              word_ok;
  logic              perm_region;
  logic [WORD_W-1:0] group_sel;
  logic [2*WORD_W-1:0] pair_sel;
  logic [WORD_W-1:0] rmask, wmask, wbits;
  logic [WORD_W-1:0] perm_rd;
  logic [PWORDS*WORD_W-1:0] perm_flat;
  logic [WORD_W-1:0] en_w [NWORDS];
  logic [WORD_W-1:0] pd_w [NWORDS];
  logic [WORD_W-1:0] pe_w [NWORDS];
  logic [WORD_W-1:0] ac_w [NWORDS];
  logic [WORD_W-1:0] en_sel, pe_sel, ac_sel;
  logic [WORD_W-1:0] rd_next;

  assign region      = region_e'(bus_word_addr[7:5]);
  assign widx        = bus_word_addr[4:0];
  assign perm_region = (region == RG_PERM_LO) || (region == RG_PERM_HI);
  assign word_ok     = !perm_region && (widx != 5'd0) && (32'(widx) < NWORDS);

  // Group bits and permission pair for the addressed word.
  always_comb begin
    group_sel = '0;
    pair_sel  = '0;
    en_sel    = '0;
    pe_sel    = '0;
    ac_sel    = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (widx == 5'(k)) begin
        group_sel = irq_group[k*WORD_W +: WORD_W];
        pair_sel  = perm_flat[k*2*WORD_W +: 2*WORD_W];
        en_sel    = en_w[k];
        pe_sel    = pe_w[k];
        ac_sel    = ac_w[k];
      end
    end
  end

  irq_access_mask u_rmask (
    .secure    (bus_secure),
    .sec_dis   (sec_disable),
    .group     (group_sel),
    .perm_pair (pair_sel),
    .need      (need_for_read(region)),
    .mask      (rmask)
  );

  irq_access_mask u_wmask (
    .secure    (bus_secure),
    .sec_dis   (sec_disable),
    .group     (group_sel),
    .perm_pair (pair_sel),
    .need      (need_for_write(region)),
    .mask      (wmask)
  );

  assign wbits = bus_wdata & wmask;

  irq_perm_store #(.NUM_IRQ(NUM_IRQ)) u_perm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && perm_region),
    .rd_sel  (perm_region),
    .secure  (bus_secure),
    .sec_dis (sec_disable),
    .idx     (bus_word_addr[5:0]),
    .wdata   (bus_wdata),
    .rd_word (perm_rd),
    .flat_o  (perm_flat)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] LIVE = (w == 0) ? '0 : '1;
    logic hit;
    logic [WORD_W-1:0] ens, enc, pds, pdc, acs, acc;

    assign hit = bus_wr && word_ok && (widx == 5'(w));
    assign ens = (hit && region == RG_SET_EN)   ? wbits : '0;
    assign enc = (hit && region == RG_CLR_EN)   ? wbits : '0;
    assign pds = (hit && region == RG_SET_PEND) ? wbits : '0;
    assign pdc = (hit && region == RG_CLR_PEND) ? wbits : '0;
    assign acs = (hit && region == RG_SET_ACT)  ? wbits : '0;
    assign acc = (hit && region == RG_CLR_ACT)  ? wbits : '0;

    irq_state_word u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (irq_level[w*WORD_W +: WORD_W] & LIVE),
      .edge_cfg (irq_edge[w*WORD_W +: WORD_W] & LIVE),
      .en_set   (ens),
      .en_clr   (enc),
      .pd_set   (pds),
      .pd_clr   (pdc),
      .ac_set   (acs),
      .ac_clr   (acc),
      .en_q     (en_w[w]),
      .pd_q     (pd_w[w]),
      .ac_q     (ac_w[w]),
      .pd_eff   (pe_w[w])
    );

    assign enable_o[w*WORD_W +: WORD_W] = en_w[w];
    assign pend_o[w*WORD_W +: WORD_W]   = pe_w[w];
    assign active_o[w*WORD_W +: WORD_W] = ac_w[w];
  end

  always_comb begin
    rd_next = '0;
    unique case (region)
      RG_SET_EN, RG_CLR_EN:     rd_next = word_ok ? (en_sel & rmask) : '0;
      RG_SET_PEND, RG_CLR_PEND: rd_next = word_ok ? (pe_sel & rmask) : '0;
      RG_SET_ACT, RG_CLR_ACT:   rd_next = word_ok ? (ac_sel & rmask) : '0;
      default:                  rd_next = perm_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R2
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !word_ok && !perm_region) |=> ($stable(enable_o) && $stable(active_o)));

endmodule

// File: tb/tb_irq_state_bank.sv
module tb_irq_state_bank;
  localparam int NUM_IRQ = 96;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_disable = 1'b0;
  logic [NUM_IRQ-1:0] irq_level = '0;
  logic [NUM_IRQ-1:0] irq_edge = '0;
  logic [NUM_IRQ-1:0] irq_group = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b1;
  logic [7:0] bus_word_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NUM_IRQ-1:0] enable_o, pend_o, active_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_bank #(.NUM_IRQ(NUM_IRQ)) dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .irq_level(irq_level), .irq_edge(irq_edge), .irq_group(irq_group),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure),
    .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .enable_o(enable_o), .pend_o(pend_o), .active_o(active_o)
  );

  function automatic logic [7:0] wa(input int region, input int idx);
    return 8'(region * 32 + idx);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec);
    bus_wr = 1'b1; bus_word_addr = a; bus_wdata = d; bus_secure = sec;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic sec, input logic [31:0] exp,
                    input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_word_addr = a; bus_secure = sec;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pops one expectation per returned read.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected rvalid actual=1 expected=0");
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled before release
    chk(32'(bus_rvalid), 0, "R1 rvalid");
    chk(bus_rdata, 0, "R1 rdata");
    rst_n = 1'b1;
    @(negedge clk);
    chk(enable_o[63:32] | pend_o[63:32] | active_o[63:32], 0, "R1 outputs");
    rd(wa(0, 1), 1'b1, 32'h0, "R1 enable word");
    rd(wa(6, 2), 1'b1, 32'h0, "R1 permission word");

    // R3 / R12 set-enable, both views
    wr(wa(0, 1), 32'h0000_00F0, 1'b1);
    chk(enable_o[63:32], 32'h0000_00F0, "R11 enable visible after write");
    wr(wa(0, 1), 32'h0000_000F, 1'b1);
    rd(wa(0, 1), 1'b1, 32'h0000_00FF, "R3 set view");
    rd(wa(1, 1), 1'b1, 32'h0000_00FF, "R3 clear view same value");
    chk(32'(bus_rvalid), 1, "R11 rvalid after read");
    @(negedge clk);
    chk(32'(bus_rvalid), 0, "R11 rvalid drops");
    // R4 clear-enable
    wr(wa(1, 1), 32'h0000_0030, 1'b1);
    rd(wa(0, 1), 1'b1, 32'h0000_00CF, "R4 clear enable");

    // R2 reserved words
    wr(wa(0, 0), 32'hFFFF_FFFF, 1'b1);
    wr(wa(0, 3), 32'hFFFF_FFFF, 1'b1);
    chk(enable_o[31:0], 0, "R2 internal word ignores write");
    chk(enable_o[95:64], 0, "R2 out-of-range write no effect");
    rd(wa(0, 0), 1'b1, 32'h0, "R2 internal word reads zero");
    rd(wa(0, 3), 1'b1, 32'h0, "R2 out-of-range reads zero");

    // R6 non-secure gated by group
    irq_group[63:32] = 32'h0000_FF00;
    wr(wa(0, 1), 32'hFFFF_FF00, 1'b0);
    chk(enable_o[63:32], 32'h0000_FFCF, "R6 NS set limited to group");
    rd(wa(0, 1), 1'b0, 32'h0000_FF00, "R6 NS read masked");

    // R5 security disabled
    sec_disable = 1'b1;
    wr(wa(0, 1), 32'h00FF_0000, 1'b0);
    rd(wa(0, 1), 1'b0, 32'h00FF_FFCF, "R5 NS full access when disabled");
    sec_disable = 1'b0;

    // R10 permission store: irq32=1, irq33=2, irq34=3
    wr(wa(6, 2), 32'h0000_0039, 1'b1);
    rd(wa(6, 2), 1'b1, 32'h0000_0039, "R10 secure readback");
    rd(wa(6, 2), 1'b0, 32'h0, "R10 NS reads zero");
    wr(wa(6, 2), 32'hFFFF_FFFF, 1'b0);
    rd(wa(6, 2), 1'b1, 32'h0000_0039, "R10 NS write ignored");
    wr(wa(6, 0), 32'hFFFF_FFFF, 1'b1);
    rd(wa(6, 0), 1'b1, 32'h0, "R10 internal permission word");

    // R7 pending and active permissions
    wr(wa(2, 1), 32'h0000_000F, 1'b0);
    rd(wa(2, 1), 1'b1, 32'h0000_0007, "R7 NS set-pend needs field>=1");
    wr(wa(3, 1), 32'h0000_000F, 1'b0);
    rd(wa(2, 1), 1'b1, 32'h0000_0001, "R7 NS clear-pend needs field>=2");
    rd(wa(2, 1), 1'b0, 32'h0000_0001, "R7 NS set-pend read");
    wr(wa(4, 1), 32'h0000_0007, 1'b1);
    rd(wa(4, 1), 1'b0, 32'h0000_0006, "R7 NS active read needs field>=2");
    wr(wa(5, 1), 32'h0000_0007, 1'b0);
    rd(wa(5, 1), 1'b1, 32'h0000_0007, "R7 NS active write ignores field");

    // R8 level merge
    irq_level[64] = 1'b1;
    #1;
    chk(32'(pend_o[64]), 1, "R8 level drives pend_o");
    rd(wa(2, 2), 1'b1, 32'h0000_0001, "R8 level read as pending");
    irq_level[64] = 1'b0;
    #1;
    chk(32'(pend_o[64]), 0, "R8 level gone, no latch");
    rd(wa(2, 2), 1'b1, 32'h0, "R8 pending readback after level drop");

    // R9 edge lines
    irq_edge[67:65] = 3'b111;
    irq_level[65] = 1'b1;
    @(negedge clk);
    irq_level[65] = 1'b0;
    @(negedge clk);
    chk(32'(pend_o[65]), 1, "R9 rise latched");
    irq_level[66] = 1'b1;
    @(negedge clk);
    wr(wa(3, 2), 32'h0000_0004, 1'b1);
    repeat (2) @(negedge clk);
    chk(32'(pend_o[66]), 0, "R9 steady level does not relatch");
    irq_level[67] = 1'b1;
    wr(wa(3, 2), 32'h0000_0008, 1'b1);
    chk(32'(pend_o[67]), 1, "R9 rise beats clear");
    rd(wa(2, 2), 1'b1, 32'h0000_000A, "R9 latch pattern");

    repeat (2) @(negedge clk);
    chk(32'(exp_q.size()), 0, "R11 all reads returned");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule